// File: doc/BRIEF.md
# Single-Outstanding Request/Response Master Monitor

This block is a passive protocol checker. It sits beside a simple request/response master port that allows only one transaction in flight, and it drives nothing on that port. Each cycle it looks at the command code, address, write data, the slave's accept strobe and the slave's response code. It decides whether that cycle is allowed, given everything seen since reset.

A write is posted: once the slave accepts it, no response follows. A read is followed by a response phase that ends with a data or error code. The slave may accept a command in the very cycle it first appears. The slave may also answer a read in the cycle it accepts it.

While a command waits for acceptance, the block stores its type, address and write data. It compares them on every later cycle. The `proto_ok` output stays high while the history is legal. It falls on the clock edge that samples the first illegal cycle and stays low until reset. `viol_pulse` marks that first violation for exactly one cycle.

Top module: `req_rsp_master_monitor`

## Requirements
- R1: While reset is asserted and right after its release, `proto_ok` is 1 and `viol_pulse` is 0.
- R2: The command codes are 3'b000 idle, 3'b001 write and 3'b010 read. Any other command code (3'b011 to 3'b111) is a violation.
- R3: The response codes are 2'b00 null, 2'b01 data valid and 2'b11 error. The code 2'b10 is a violation in any cycle.
- R4: A write may be accepted in its first cycle, or held for any number of cycles with unchanged type, address and data until `slv_accept` is 1. No response is expected after an accepted write, and all of these cycles are legal.
- R5: Before acceptance, a change of command type, a change of address, or (for writes) a change of write data is a violation. During an unaccepted read, the write-data bus is ignored.
- R6: An accepted read is answered by zero or more null-response cycles and then a data-valid or error response. The answer may arrive in the accept cycle, including the cycle in which the read first appears.
- R7: While an accepted read still awaits its response, any non-idle command is a violation.
- R8: A non-null response is a violation when no accepted read is awaiting one. This covers idle cycles, write cycles and reads that have not yet been accepted.
- R9: A violation sampled at clock edge k makes `proto_ok` 0 after edge k until reset, and `viol_pulse` 1 for that one cycle only. Later violations produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_code | input | 3 | Command code presented by the master |
| cmd_addr | input | AW | Address presented with the command |
| cmd_wdata | input | DW | Write data presented with a write |
| slv_accept | input | 1 | Slave accepts the current command |
| slv_resp | input | 2 | Slave response code |
| proto_ok | output | 1 | High while every cycle since reset was legal |
| viol_pulse | output | 1 | One-cycle marker of the first violation |

## Verification
The bench targets the zero-wait corners: a read accepted and answered in its first cycle, and a write accepted at once. A monitor that assumed at least one wait state would flag these legal cycles. It also changes write data during an unaccepted read, which a design comparing data for every command would reject wrongly. It issues a command while a read response is pending and sends stray responses during idle, write and unaccepted-read cycles, which a monitor with loose phase tracking would let pass. Back-to-back violations check that the flag stays low and that no second pulse appears.

// File: rtl/rrm_pkg.sv
package rrm_pkg;
  localparam int CMD_W = 3;
  localparam int RSP_W = 2;

  localparam logic [CMD_W-1:0] OP_IDLE  = 3'b000;
  localparam logic [CMD_W-1:0] OP_WRITE = 3'b001;
  localparam logic [CMD_W-1:0] OP_READ  = 3'b010;

  localparam logic [RSP_W-1:0] RS_NULL = 2'b00;
  localparam logic [RSP_W-1:0] RS_DATA = 2'b01;
  localparam logic [RSP_W-1:0] RS_RSVD = 2'b10;
  localparam logic [RSP_W-1:0] RS_ERR  = 2'b11;

  // FREE: no command pending, HOLD: command shown but not accepted,
  // AWAIT: read accepted, response still owed
  typedef enum logic [1:0] {PH_FREE, PH_HOLD, PH_AWAIT} phase_e;
endpackage

// File: rtl/rrm_hold_store.sv
module rrm_hold_store #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     capture,
  input  logic [rrm_pkg::CMD_W-1:0] cmd_code,
  input  logic [AW-1:0]            cmd_addr,
  input  logic [DW-1:0]            cmd_wdata,
  output logic                     same_cmd,
  output logic                     same_addr,
  output logic                     same_data
);
  logic [rrm_pkg::CMD_W-1:0] held_cmd;
  logic [AW-1:0]             held_addr;
  logic [DW-1:0]             held_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_cmd  <= '0;
      held_addr <= '0;
      held_data <= '0;
    end else if (capture) begin
      held_cmd  <= cmd_code;
      held_addr <= cmd_addr;
      held_data <= cmd_wdata;
    end
  end

  assign same_cmd  = (held_cmd == cmd_code);
  assign same_addr = (held_addr == cmd_addr);
  assign same_data = (held_data == cmd_wdata);
endmodule

// File: rtl/rrm_phase_tracker.sv
module rrm_phase_tracker
  import rrm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             slv_accept,
  input  logic [RSP_W-1:0] slv_resp,
  input  logic             same_cmd,
  input  logic             same_addr,
  input  logic             same_data,
  output logic             capture,
  output logic             bad
);
  phase_e phase_q, phase_d;
  logic   is_idle, is_write, is_read, cmd_rsvd;
  logic   rsp_null, rsp_end, rsp_rsvd;

  assign is_idle  = (cmd_code == OP_IDLE);
  assign is_write = (cmd_code == OP_WRITE);
  assign is_read  = (cmd_code == OP_READ);
  assign cmd_rsvd = !(is_idle || is_write || is_read);
  assign rsp_null = (slv_resp == RS_NULL);
  assign rsp_rsvd = (slv_resp == RS_RSVD);
  assign rsp_end  = (slv_resp == RS_DATA) || (slv_resp == RS_ERR);

  always_comb begin
    phase_d = phase_q;
    capture = 1'b0;
    bad     = cmd_rsvd || rsp_rsvd;
    unique case (phase_q)
      PH_FREE, PH_HOLD: begin
        if (phase_q == PH_HOLD &&
            !(same_cmd && same_addr && (!is_write || same_data)))
          bad = 1'b1;
        if (is_write) begin
          if (!rsp_null) bad = 1'b1;
          if (slv_accept) begin
            phase_d = PH_FREE;
          end else begin
            phase_d = PH_HOLD;
            capture = (phase_q == PH_FREE);
          end
        end else if (is_read) begin
          if (slv_accept) begin
            phase_d = rsp_null ? PH_AWAIT : PH_FREE;
          end else begin
            if (!rsp_null) bad = 1'b1;
            phase_d = PH_HOLD;
            capture = (phase_q == PH_FREE);
          end
        end else begin
          if (!rsp_null) bad = 1'b1;
          phase_d = PH_FREE;
        end
      end
      PH_AWAIT: begin
        if (!is_idle) bad = 1'b1;
        if (rsp_end) phase_d = PH_FREE;
      end
      default: phase_d = PH_FREE;
    endcase
    if (bad) phase_d = PH_FREE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_FREE;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/req_rsp_master_monitor.sv
module req_rsp_master_monitor #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cmd_code,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  input  logic          slv_accept,
  input  logic [1:0]    slv_resp,
  output logic          proto_ok,
  output logic          viol_pulse
);
  logic capture, bad, same_cmd, same_addr, same_data;
  logic ok_q, ok_d, pulse_q, pulse_d;

  rrm_hold_store #(.AW(AW), .DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .capture(capture),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .same_cmd(same_cmd), .same_addr(same_addr), .same_data(same_data)
  );

  rrm_phase_tracker u_phase (
    .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code),
    .slv_accept(slv_accept), .slv_resp(slv_resp),
    .same_cmd(same_cmd), .same_addr(same_addr), .same_data(same_data),
    .capture(capture), .bad(bad)
  );

  always_comb begin
    ok_d    = ok_q && !bad;
    pulse_d = ok_q && bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q    <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      ok_q    <= ok_d;
      pulse_q <= pulse_d;
    end
  end

  assign proto_ok   = ok_q;
  assign viol_pulse = pulse_q;
endmodule

// File: rtl/rrm_monitor_chk.sv
module rrm_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] cmd_code,
  input logic [1:0] slv_resp,
  input logic       proto_ok,
  input logic       viol_pulse
);
  // R9
  sticky_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !proto_ok |=> !proto_ok);
  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |=> !viol_pulse);
  // R9
  pulse_low_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> !proto_ok);
  // R9
  fall_has_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_ok |=> (proto_ok || viol_pulse));
  // R2
  rsvd_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_ok && cmd_code > 3'b010) |=> viol_pulse);
  // R3
  rsvd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_ok && slv_resp == 2'b10) |=> viol_pulse);
endmodule

bind req_rsp_master_monitor rrm_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .slv_resp(slv_resp),
  .proto_ok(proto_ok), .viol_pulse(viol_pulse)
);

// File: tb/tb_req_rsp_master_monitor.sv
module tb_req_rsp_master_monitor;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    cmd_code;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata;
  logic          slv_accept;
  logic [1:0]    slv_resp;
  logic          proto_ok, viol_pulse;

  typedef struct {
    logic  ok;
    logic  pulse;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  logic m_ok  = 1'b1;

  always #2 clk = ~clk;

  req_rsp_master_monitor #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .slv_accept(slv_accept), .slv_resp(slv_resp),
    .proto_ok(proto_ok), .viol_pulse(viol_pulse)
  );

  task automatic compare(string tag, logic aok, logic ap, logic eok, logic ep);
    n_cmp++;
    if (aok !== eok || ap !== ep) begin
      n_bad++;
      $display("FAIL %s: ok/pulse actual %b/%b expected %b/%b", tag, aok, ap, eok, ep);
    end
  endtask

  // monitor: pops one expected item per driven cycle
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compare(e.tag, proto_ok, viol_pulse, e.ok, e.pulse);
    end
  end

  task automatic step(logic [2:0] c, logic [AW-1:0] a, logic [DW-1:0] d,
                      logic acc, logic [1:0] r, logic viol, string tag);
    exp_t e;
    @(negedge clk);
    cmd_code = c; cmd_addr = a; cmd_wdata = d; slv_accept = acc; slv_resp = r;
    e.pulse = viol && m_ok;
    m_ok    = m_ok && !viol;
    e.ok    = m_ok;
    e.tag   = tag;
    q.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_code = 3'b000; cmd_addr = '0; cmd_wdata = '0; slv_accept = 1'b0; slv_resp = 2'b00;
    repeat (2) @(negedge clk);
    compare("R1 during reset", proto_ok, viol_pulse, 1'b1, 1'b0);
    rst_n = 1'b1;
    m_ok  = 1'b1;
    @(negedge clk);
    compare("R1 after release", proto_ok, viol_pulse, 1'b1, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    cmd_code = 3'b000; cmd_addr = '0; cmd_wdata = '0; slv_accept = 1'b0; slv_resp = 2'b00;
    do_reset();
    // R4 writes: immediate accept and held accept
    step(3'b001, 32'h10, 32'h5, 1'b1, 2'b00, 1'b0, "R4 write same-cycle accept");
    step(3'b000, 32'h0,  32'h0, 1'b0, 2'b00, 1'b0, "R4 idle after posted write");
    step(3'b001, 32'h20, 32'h6, 1'b0, 2'b00, 1'b0, "R4 write waiting");
    step(3'b001, 32'h20, 32'h6, 1'b0, 2'b00, 1'b0, "R4 write held");
    step(3'b001, 32'h20, 32'h6, 1'b1, 2'b00, 1'b0, "R4 write accepted late");
    step(3'b000, 32'h0,  32'h0, 1'b0, 2'b00, 1'b0, "R4 idle");
    // R5 address change
    do_reset();
    step(3'b001, 32'h30, 32'h1, 1'b0, 2'b00, 1'b0, "R5 write waiting");
    step(3'b001, 32'h31, 32'h1, 1'b0, 2'b00, 1'b1, "R5 address changed");
    step(3'b000, 32'h0,  32'h0, 1'b0, 2'b00, 1'b0, "R9 stays low");
    // R5 data change
    do_reset();
    step(3'b001, 32'h40, 32'h1, 1'b0, 2'b00, 1'b0, "R5 write waiting");
    step(3'b001, 32'h40, 32'h2, 1'b1, 2'b00, 1'b1, "R5 data changed");
    // R5 read ignores data bus, then type change
    do_reset();
    step(3'b010, 32'h50, 32'h1, 1'b0, 2'b00, 1'b0, "R5 read waiting");
    step(3'b010, 32'h50, 32'h9, 1'b0, 2'b00, 1'b0, "R5 read data bus ignored");
    step(3'b010, 32'h50, 32'h3, 1'b1, 2'b01, 1'b0, "R6 accept with data");
    step(3'b000, 32'h0,  32'h0, 1'b0, 2'b00, 1'b0, "R6 idle after read");
    step(3'b010, 32'h60, 32'h0, 1'b0, 2'b00, 1'b0, "R5 read waiting");
    step(3'b001, 32'h60, 32'h0, 1'b0, 2'b00, 1'b1, "R5 type changed");
    // R6 response shapes
    do_reset();
    step(3'b010, 32'h70, 32'h0, 1'b1, 2'b01, 1'b0, "R6 first-cycle accept and data");
    step(3'b010, 32'h74, 32'h0, 1'b1, 2'b00, 1'b0, "R6 accept null");
    step(3'b000, 32'h0,  32'h0, 1'b0, 2'b00, 1'b0, "R6 wait 1");
    step(3'b000, 32'h0,  32'h0, 1'b0, 2'b00, 1'b0, "R6 wait 2");
    step(3'b000, 32'h0,  32'h0, 1'b0, 2'b11, 1'b0, "R6 error ends read");
    step(3'b000, 32'h0,  32'h0, 1'b0, 2'b00, 1'b0, "R6 idle");
    step(3'b010, 32'h78, 32'h0, 1'b0, 2'b00, 1'b0, "R6 read waiting");
    step(3'b010, 32'h78, 32'h0, 1'b1, 2'b11, 1'b0, "R6 accept with error");
    step(3'b000, 32'h0,  32'h0, 1'b0, 2'b00, 1'b0, "R6 idle");
    // R7 command while read pending
    do_reset();
    step(3'b010, 32'h80, 32'h0, 1'b1, 2'b00, 1'b0, "R7 read accepted");
    step(3'b001, 32'h84, 32'h0, 1'b0, 2'b00, 1'b1, "R7 write while pending");
    // R8 stray responses
    do_reset();
    step(3'b000, 32'h0,  32'h0, 1'b0, 2'b01, 1'b1, "R8 data on idle");
    do_reset();
    step(3'b001, 32'h90, 32'h0, 1'b1, 2'b11, 1'b1, "R8 error on write");
    do_reset();
    step(3'b010, 32'h94, 32'h0, 1'b0, 2'b01, 1'b1, "R8 data before accept");
    // R2 / R3 reserved codes
    do_reset();
    step(3'b100, 32'h0,  32'h0, 1'b0, 2'b00, 1'b1, "R2 reserved command");
    do_reset();
    step(3'b000, 32'h0,  32'h0, 1'b0, 2'b10, 1'b1, "R3 reserved response idle");
    do_reset();
    step(3'b010, 32'hA0, 32'h0, 1'b1, 2'b00, 1'b0, "R3 read accepted");
    step(3'b000, 32'h0,  32'h0, 1'b0, 2'b10, 1'b1, "R3 reserved response pending");
    // R9 repeated violations
    do_reset();
    step(3'b111, 32'h0,  32'h0, 1'b0, 2'b00, 1'b1, "R9 first violation");
    step(3'b011, 32'h0,  32'h0, 1'b0, 2'b00, 1'b1, "R9 second violation no pulse");
    step(3'b000, 32'h0,  32'h0, 1'b0, 2'b00, 1'b0, "R9 low on idle");
    step(3'b001, 32'hB0, 32'h1, 1'b1, 2'b00, 1'b0, "R9 low on legal write");
    do_reset();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule